// File: doc/BRIEF.md
# SRAM Pattern Sweep Tester

This block tests the lowest 256 locations of a byte-wide asynchronous static RAM. A single 8-bit counter serves as both the address and the source of the write pattern. The block first writes the whole range in one ascending sweep. It then reads the range back in a second ascending sweep and compares each word with the value it expects. Chip select and output enable stay asserted for the whole test. Write enable is active low, and the same condition that pulls it low also drives the write pattern onto the shared data bus.

Two patterns are available, and the mode is captured when the test starts. In address mode, every location holds its own address. Checkerboard mode makes two complete write/read passes: the first uses a checkerboard pattern and the second uses its inverse. The test ends in a fail state at the first mismatching compare, with the offending address held on an output. Otherwise it ends in a pass state after every compare has matched. The pass or fail result stays visible until the next start.

Top module: `sram_sweep_tester`

## Requirements
- R1: After reset, busy, passFlag and failFlag are low, weN is high and the tester drives nothing onto memData.
- R2: A pulse on start from idle, pass or fail begins a write sweep on the next clock. The sweep takes one clock per location, for addresses 0 to 255 in ascending order, with weN low and the pattern driven on memData. In address mode the byte written to address n is n.
- R3: Reading starts only after the write at address 255. It visits addresses 0 to 255 in ascending order, one per clock, with weN high and memData released by the tester.
- R4: On a read compare that mismatches, failFlag is set and busy is cleared on the next clock. failAddr holds the address of that compare, and no further locations are visited.
- R5: passFlag is set on the clock after the last read of the final pass, and only if every compare in the test matched.
- R6: In checkerboard mode the first pass writes 0x55 at even addresses and 0xAA at odd addresses. The second pass writes 0xAA at even addresses and 0x55 at odd addresses.
- R7: In checkerboard mode a clean first pass is followed directly by the inverted write sweep, so a clean test performs 512 write cycles before passFlag is set.
- R8: passFlag and failFlag hold their value until the next start. A start in either state clears the result and begins a new test.
- R9: csN and oeN are held low at all times.
- R10: checkerMode is sampled only on the clock that accepts start. Changing it during a test has no effect on the patterns or on the number of passes.
- R11: A mismatch at address 255 takes precedence over the end of the sweep: failFlag is set with failAddr equal to 255, and passFlag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one memory access per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a test when not busy |
| checkerMode | input | 1 | 0 = address pattern, 1 = checkerboard then inverse |
| memAddr | output | 8 | RAM address (counter value) |
| memData | inout | 8 | Shared RAM data bus, driven only while writing |
| weN | output | 1 | Active-low write enable, also enables the bus driver |
| csN | output | 1 | Active-low chip select, held low |
| oeN | output | 1 | Active-low output enable, held low |
| busy | output | 1 | High during write and read sweeps |
| passFlag | output | 1 | Test completed with every compare matching |
| failFlag | output | 1 | Test stopped at a mismatch |
| failAddr | output | 8 | Address of the first mismatch |

## Verification
The last read of a sweep can also be the first mismatch. In that cycle the terminal count and the compare failure are both present, and the two conditions send the controller to different states. The bench provokes this with a RAM model whose location 255 has one bit stuck at zero, and it requires fail with failAddr 255 and no pass. A second collision happens in checkerboard mode, where a stuck-at-one bit passes the first pass but fails the inverted one. This case checks that the switch to the second pass happens in the same cycle as a compare that must still be judged. A behavioural reference model predicts every output cycle by cycle and is compared at every negative clock edge.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAIL  = 3'd4
  } sweepState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic phaseClear;
    logic phaseSet;
    logic modeLoad;
    logic failLatch;
    logic driveEn;
  } sweepStrobe_t;

endpackage

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepStrobe_t      stb,
  input  logic              checkerIn,
  input  logic [ADDR_W-1:0] busIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] busOut,
  output logic              busOe,
  output logic              term,
  output logic              match,
  output logic              needInverse,
  output logic [ADDR_W-1:0] failAddr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] cnt;
  logic              phase;
  logic              modeReg;
  logic [ADDR_W-1:0] failAddrReg;
  logic [ADDR_W-1:0] checkerWord;
  logic [ADDR_W-1:0] expected;

  // Address / pattern counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.cntClear) begin
      cnt <= '0;
    end else if (stb.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Pass phase and captured mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      modeReg <= 1'b0;
    end else begin
      if (stb.phaseClear) begin
        phase <= 1'b0;
      end else if (stb.phaseSet) begin
        phase <= 1'b1;
      end
      if (stb.modeLoad) begin
        modeReg <= checkerIn;
      end
    end
  end

  // Alternating bit pattern: even bit positions set for phase 0, even address
  for (genvar b = 0; b < ADDR_W; b++) begin : g_chk
    localparam logic BASE_BIT = (b % 2 == 0) ? 1'b1 : 1'b0;
    assign checkerWord[b] = BASE_BIT ^ cnt[0] ^ phase;
  end

  always_comb begin
    expected = modeReg ? checkerWord : cnt;
  end

  // First failing address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failAddrReg <= '0;
    end else if (stb.failLatch) begin
      failAddrReg <= cnt;
    end
  end

  assign addrOut     = cnt;
  assign busOut      = expected;
  assign busOe       = stb.driveEn;
  assign term        = (cnt == LAST_ADDR);
  assign match       = (busIn == expected);
  assign needInverse = modeReg & ~phase;
  assign failAddr    = failAddrReg;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntInc && !stb.cntClear) |=> (cnt == $past(cnt) + 1'b1)); // R2

  AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.failLatch |=> $stable(failAddrReg)); // R4

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !stb.modeLoad |=> $stable(modeReg)); // R10

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         term,
  input  logic         match,
  input  logic         needInverse,
  output sweepStrobe_t stb,
  output logic         busy,
  output logic         passFlag,
  output logic         failFlag,
  output logic         weN
);

  sweepState_e state;
  sweepState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start) begin
          nextState      = ST_WRITE;
          stb.cntClear   = 1'b1;
          stb.phaseClear = 1'b1;
          stb.modeLoad   = 1'b1;
        end
      end
      ST_WRITE: begin
        stb.driveEn = 1'b1;
        if (term) begin
          nextState    = ST_READ;
          stb.cntClear = 1'b1;
        end else begin
          stb.cntInc = 1'b1;
        end
      end
      ST_READ: begin
        if (!match) begin
          nextState     = ST_FAIL;
          stb.failLatch = 1'b1;
        end else if (term) begin
          if (needInverse) begin
            nextState    = ST_WRITE;
            stb.cntClear = 1'b1;
            stb.phaseSet = 1'b1;
          end else begin
            nextState = ST_PASS;
          end
        end else begin
          stb.cntInc = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state == ST_WRITE) || (state == ST_READ);
  assign passFlag = (state == ST_PASS);
  assign failFlag = (state == ST_FAIL);
  assign weN      = (state != ST_WRITE);

  AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && !match) |=> (failFlag && !passFlag)); // R11

  AST_PASS_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passFlag) |-> ($past(term) && $past(match))); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((passFlag || failFlag) && !start) |=> $stable({passFlag, failFlag})); // R8

  AST_WRITE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE && term) |=> (weN && busy)); // R3

endmodule

// File: rtl/sram_sweep_tester.sv
module sram_sweep_tester
  import sweep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              checkerMode,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [ADDR_W-1:0] memData,
  output logic              weN,
  output logic              csN,
  output logic              oeN,
  output logic              busy,
  output logic              passFlag,
  output logic              failFlag,
  output logic [ADDR_W-1:0] failAddr
);

  sweepStrobe_t      stb;
  logic              term;
  logic              match;
  logic              needInverse;
  logic [ADDR_W-1:0] busOut;
  logic              busOe;

  sweep_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .term       (term),
    .match      (match),
    .needInverse(needInverse),
    .stb        (stb),
    .busy       (busy),
    .passFlag   (passFlag),
    .failFlag   (failFlag),
    .weN        (weN)
  );

  sweep_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .checkerIn  (checkerMode),
    .busIn      (memData),
    .addrOut    (memAddr),
    .busOut     (busOut),
    .busOe      (busOe),
    .term       (term),
    .match      (match),
    .needInverse(needInverse),
    .failAddr   (failAddr)
  );

  assign memData = busOe ? busOut : {ADDR_W{1'bz}};
  assign csN     = 1'b0;
  assign oeN     = 1'b0;

  AST_FAIL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> (failAddr == $past(memAddr))); // R4

  AST_DRIVE_MATCHES_WE: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !weN); // R3

endmodule

// File: tb/tb_sram_sweep_tester.sv
module tb_sram_sweep_tester;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       checkerMode = 1'b0;
  logic [7:0] memAddr;
  wire  [7:0] memData;
  logic       weN, csN, oeN, busy, passFlag, failFlag;
  logic [7:0] failAddr;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  int weLow = 0;

  logic [7:0] ram [256];
  int         faultAddr = -1;
  logic [7:0] setMask = 8'h00;
  logic [7:0] clrMask = 8'h00;
  logic [7:0] ramRead;

  // Reference model
  int         rs = 0;   // 0 idle 1 write 2 read 3 pass 4 fail
  int         refCnt = 0;
  int         refPhase = 0;
  int         refMode = 0;
  int         refFailAddr = 0;

  always #2 clk = ~clk;

  sram_sweep_tester dut (
    .clk(clk), .rstN(rstN), .start(start), .checkerMode(checkerMode),
    .memAddr(memAddr), .memData(memData), .weN(weN), .csN(csN), .oeN(oeN),
    .busy(busy), .passFlag(passFlag), .failFlag(failFlag), .failAddr(failAddr)
  );

  function automatic logic [7:0] readVal(int a);
    logic [7:0] v;
    v = ram[a];
    if (a == faultAddr) v = (v | setMask) & ~clrMask;
    return v;
  endfunction

  function automatic logic [7:0] pat(int c, int mode, int ph);
    if (mode == 0) return 8'(c);
    return ((c % 2) ^ ph) != 0 ? 8'hAA : 8'h55;
  endfunction

  always_comb ramRead = readVal(int'(memAddr));
  assign memData = weN ? ramRead : 8'hzz;

  always @(negedge clk) begin
    if (rstN && !weN) ram[memAddr] <= memData;
  end

  always @(negedge clk) begin
    if (!weN) weLow++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Reference model update
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      rs = 0; refCnt = 0; refPhase = 0; refMode = 0; refFailAddr = 0;
    end else begin
      case (rs)
        0, 3, 4: if (start) begin
          rs = 1; refCnt = 0; refPhase = 0; refMode = checkerMode ? 1 : 0;
        end
        1: if (refCnt == 255) begin rs = 2; refCnt = 0; end
           else refCnt++;
        2: if (readVal(refCnt) != pat(refCnt, refMode, refPhase)) begin
             rs = 4; refFailAddr = refCnt;
           end else if (refCnt == 255) begin
             if (refMode == 1 && refPhase == 0) begin
               rs = 1; refPhase = 1; refCnt = 0;
             end else rs = 3;
           end else refCnt++;
        default: rs = 0;
      endcase
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      check(busy == (rs == 1 || rs == 2), "R2 busy", int'(busy), int'(rs == 1 || rs == 2));
      check(passFlag == (rs == 3), "R5 passFlag", int'(passFlag), int'(rs == 3));
      check(failFlag == (rs == 4), "R4 failFlag", int'(failFlag), int'(rs == 4));
      check(weN == (rs != 1), "R3 weN", int'(weN), int'(rs != 1));
      check(csN == 1'b0 && oeN == 1'b0, "R9 csN/oeN", int'({csN, oeN}), 0);
      if (rs == 1 || rs == 2)
        check(memAddr == 8'(refCnt), "R3 memAddr", int'(memAddr), refCnt);
      if (rs == 1)
        check(memData == pat(refCnt, refMode, refPhase),
              refMode != 0 ? "R6 write data" : "R2 write data",
              int'(memData), int'(pat(refCnt, refMode, refPhase)));
      if (rs == 4)
        check(failAddr == 8'(refFailAddr), "R4 failAddr", int'(failAddr), refFailAddr);
    end
  end

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finishRun();
    end
  end

  task automatic runTest(input logic mode, input bit flipMid);
    @(negedge clk);
    checkerMode = mode;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    weLow = 0;
    for (int i = 0; i < 3000; i++) begin
      if (flipMid && i == 100) checkerMode = ~checkerMode;
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) ram[a] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 0 && passFlag == 0 && failFlag == 0, "R1 flags", int'({busy, passFlag, failFlag}), 0);
    check(weN == 1'b1, "R1 weN", int'(weN), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !passFlag && !failFlag, "R1 idle after reset", int'({busy, passFlag, failFlag}), 0);

    // Address mode, clean
    runTest(1'b0, 1'b0);
    check(passFlag == 1'b1, "R5 address clean pass", int'(passFlag), 1);
    check(weLow == 256, "R2 write cycles", weLow, 256);
    repeat (20) @(negedge clk);
    check(passFlag == 1'b1 && !busy, "R8 pass held", int'(passFlag), 1);

    // Address mode, stuck-at-one at 37
    faultAddr = 37; setMask = 8'h80; clrMask = 8'h00;
    runTest(1'b0, 1'b0);
    check(failFlag == 1'b1, "R4 mismatch fails", int'(failFlag), 1);
    check(failAddr == 8'd37, "R4 failAddr 37", int'(failAddr), 37);
    repeat (10) @(negedge clk);
    check(failFlag == 1'b1 && failAddr == 8'd37, "R8 fail held", int'(failAddr), 37);

    // Checkerboard, clean, mode toggled during run
    faultAddr = -1; setMask = 8'h00;
    runTest(1'b1, 1'b1);
    check(passFlag == 1'b1, "R7 checker pass", int'(passFlag), 1);
    check(weLow == 512, "R7 two write sweeps (R10 toggle ignored)", weLow, 512);

    // Address mode with mode toggled high mid run
    runTest(1'b0, 1'b1);
    check(weLow == 256, "R10 single sweep despite toggle", weLow, 256);
    check(passFlag == 1'b1, "R10 pass", int'(passFlag), 1);

    // Checkerboard, fault visible only in inverted pass
    faultAddr = 10; setMask = 8'h01; clrMask = 8'h00;
    runTest(1'b1, 1'b0);
    check(failFlag == 1'b1, "R6 inverse pass fault", int'(failFlag), 1);
    check(failAddr == 8'd10, "R6 failAddr 10", int'(failAddr), 10);
    check(weLow == 512, "R7 fault after second write", weLow, 512);

    // Mismatch on the terminal address
    faultAddr = 255; setMask = 8'h00; clrMask = 8'h01;
    runTest(1'b0, 1'b0);
    check(failFlag == 1'b1 && passFlag == 1'b0, "R11 fail over pass", int'({failFlag, passFlag}), 2);
    check(failAddr == 8'd255, "R11 failAddr 255", int'(failAddr), 255);

    // Restart from fail, clean
    faultAddr = -1; clrMask = 8'h00;
    runTest(1'b0, 1'b0);
    check(passFlag == 1'b1 && failFlag == 1'b0, "R8 restart clears fail", int'({passFlag, failFlag}), 2);

    finishRun();
  end

endmodule